// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives the fixed power-up and mode-register programming sequence that a DDR2 SDRAM needs after its controller leaves reset. A single start pulse launches the run. The block then puts out fourteen commands, one at a time, on a packed command word with a one-cycle valid strobe. Between commands it holds the bus idle for a parameterised number of clock cycles. Each gap is set by the timing rule that applies to the command just issued: precharge, refresh, mode-register write, the DLL lock time, or the settle time after the opening NOP.

The contents of the mode registers come from three configuration inputs, which are captured when the start pulse is accepted. CAS latency and write recovery go into the main mode register. The number of populated DIMMs selects the on-die termination and the output drive strength written to the first extended mode register. A configuration the block cannot program raises an error flag, and the sequence does not start. No command goes out until a power-up interval, counted from reset, has elapsed. A busy flag covers the whole run, and a done flag marks its completion.

Top module: `ddr2_init_seq`

## Requirements
- R1: During and directly after reset, busy, done, cfgError and cmdValid are low and cmdWord holds the idle word 0x380000 (NOP code, everything else zero); whenever cmdValid is low, cmdWord holds that idle word.
- R2: cmdWord carries the command code in bits 21:19 (mode-register set 0, refresh 1, precharge 2, NOP 7), bit 18 is always zero, bits 17:16 select the mode register (MR 0, EMR 1, EMR2 2, EMR3 3; zero for other commands) and bits 15:0 carry the address.
- R3: An accepted start produces exactly fourteen commands in this order: NOP, precharge-all, EMR2, EMR3, EMR with DLL enabled, MR with DLL reset, precharge-all, four refreshes, MR without DLL reset, EMR with OCD default, EMR with OCD exit.
- R4: MR address = 0x2 (burst length 4) OR CAS latency shifted left by 4 OR (write recovery − 1) shifted left by 9, with bit 8 (DLL reset) set only in the first MR write.
- R5: EMR address is 0x040 (150 ohm termination, full drive) with one DIMM and 0x006 (75 ohm termination, reduced drive) with two; the OCD-default write ORs in 0x380, while the DLL-enable and OCD-exit writes leave bits 9:7 clear; EMR2 and EMR3 writes carry address 0; precharge-all carries 0x400 (A10); NOP and refresh carry 0.
- R6: The next command follows a command by exactly T_NOP cycles after the NOP, T_RP after a precharge, T_RFC after a refresh, T_DLL after the DLL-reset MR write and T_MRD after any other mode write; done rises T_MRD cycles after the final command.
- R7: No command is issued until PWRUP_CYCLES clocks have passed since reset release; a start given at reset release yields the first command at release + PWRUP_CYCLES + 2, and once that interval has passed the first command follows two clocks after the edge that samples start.
- R8: A start with CAS latency outside 3..5, write recovery outside 2..6 or DIMM count outside 1..2 sets cfgError on the next edge, leaves busy low and issues no command; the next accepted valid start clears cfgError.
- R9: busy goes high on the edge that accepts start and falls on the edge that raises done; a start pulse or a configuration change while busy has no effect on the running sequence.
- R10: done stays high after completion until the next accepted start clears it; done and busy are never high together, and cmdValid pulses last one cycle and occur only while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, acted on only while idle |
| casLat | input | 3 | CAS latency in cycles |
| wrRecov | input | 3 | Write recovery in cycles |
| dimmCount | input | 2 | Number of populated DIMMs |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, held until the next start |
| cfgError | output | 1 | Last start request had an unsupported configuration |
| cmdValid | output | 1 | cmdWord carries a command this cycle |
| cmdWord | output | 22 | Packed command, register select and address |

## Verification
Busy and cfgError change on the edge that samples start. When the power-up interval has already passed, the first command appears three negative-edge samples after start is driven. Each later command follows the previous one by exactly the gap tied to that command, and done follows the last command by T_MRD. The bench stamps every cmdValid and the rise of done with a cycle counter at the falling edge, and compares the differences of those stamps with the required gaps instead of polling for eventual values. For a start given at reset release, it checks the first command's stamp against release + PWRUP_CYCLES + 2.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  localparam int CMD_WORD_W = 22;
  localparam int ADDR_FIELD_W = 16;
  localparam int NUM_STEPS = 14;

  // Command code as driven in cmdWord[21:19]
  typedef enum logic [2:0] {
    CMD_MRS = 3'd0,
    CMD_REF = 3'd1,
    CMD_PRE = 3'd2,
    CMD_WR  = 3'd4,
    CMD_RD  = 3'd5,
    CMD_NOP = 3'd7
  } cmdCode_e;

  // Mode register select as driven in cmdWord[17:16]
  typedef enum logic [1:0] {
    SEL_MR   = 2'd0,
    SEL_EMR  = 2'd1,
    SEL_EMR2 = 2'd2,
    SEL_EMR3 = 2'd3
  } modeSel_e;

  // Position in the init sequence; the order is the behaviour
  typedef enum logic [3:0] {
    ST_NOP      = 4'd0,
    ST_PRE_A    = 4'd1,
    ST_EMR2     = 4'd2,
    ST_EMR3     = 4'd3,
    ST_EMR_DLL  = 4'd4,
    ST_MR_RST   = 4'd5,
    ST_PRE_B    = 4'd6,
    ST_REF0     = 4'd7,
    ST_REF1     = 4'd8,
    ST_REF2     = 4'd9,
    ST_REF3     = 4'd10,
    ST_MR_RUN   = 4'd11,
    ST_EMR_OCD  = 4'd12,
    ST_EMR_EXIT = 4'd13,
    ST_FINISH   = 4'd14
  } step_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  latchCfg;
    logic  issue;
    step_e step;
  } seqStrobe_t;

  localparam logic [CMD_WORD_W-1:0] IDLE_WORD = 22'h380000;

  function automatic logic [CMD_WORD_W-1:0] packCmd(cmdCode_e code, modeSel_e sel,
                                                    logic [ADDR_FIELD_W-1:0] addr);
    return {code, 1'b0, sel, addr};
  endfunction

endpackage

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int PWRUP_CYCLES = 40000,
  parameter int T_NOP = 100,
  parameter int T_RP = 4,
  parameter int T_MRD = 2,
  parameter int T_RFC = 26,
  parameter int T_DLL = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cfgOk,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       cfgError
);

  // Gaps shorter than two cycles cannot be met by the issue/wait loop
  localparam int W_NOP = (T_NOP < 2) ? 2 : T_NOP;
  localparam int W_RP  = (T_RP  < 2) ? 2 : T_RP;
  localparam int W_MRD = (T_MRD < 2) ? 2 : T_MRD;
  localparam int W_RFC = (T_RFC < 2) ? 2 : T_RFC;
  localparam int W_DLL = (T_DLL < 2) ? 2 : T_DLL;
  localparam int MAX_A = (W_NOP > W_RP) ? W_NOP : W_RP;
  localparam int MAX_B = (W_MRD > W_RFC) ? W_MRD : W_RFC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_W = (MAX_C > W_DLL) ? MAX_C : W_DLL;
  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam int PWR_LIM = (PWRUP_CYCLES < 1) ? 1 : PWRUP_CYCLES;
  localparam int PWR_W = $clog2(PWR_LIM + 1);

  typedef enum logic [1:0] {S_IDLE, S_PWR, S_ISSUE, S_WAIT} state_e;

  state_e state;
  step_e step;
  logic [CNT_W-1:0] waitCnt;
  logic [PWR_W-1:0] pwrCnt;
  logic pwrOk;
  logic accept;

  // Counter load for the gap after a step: the issue edge and the
  // zero-detect edge account for the remaining two cycles
  function automatic logic [CNT_W-1:0] waitLoad(step_e s);
    case (s)
      ST_NOP:                              return CNT_W'(W_NOP - 2);
      ST_PRE_A, ST_PRE_B:                  return CNT_W'(W_RP - 2);
      ST_MR_RST:                           return CNT_W'(W_DLL - 2);
      ST_REF0, ST_REF1, ST_REF2, ST_REF3:  return CNT_W'(W_RFC - 2);
      default:                             return CNT_W'(W_MRD - 2);
    endcase
  endfunction

  assign accept = (state == S_IDLE) && start;
  assign busy = (state != S_IDLE);

  always_comb begin
    strb.latchCfg = accept && cfgOk;
    strb.issue = (state == S_ISSUE) && (step != ST_FINISH);
    strb.step = step;
  end

  // Power-up interval, counted once from reset release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrCnt <= '0;
      pwrOk <= 1'b0;
    end else if (!pwrOk) begin
      pwrCnt <= pwrCnt + 1'b1;
      pwrOk <= (pwrCnt == PWR_W'(PWR_LIM - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step <= ST_NOP;
      waitCnt <= '0;
      done <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            done <= 1'b0;
            if (cfgOk) begin
              cfgError <= 1'b0;
              step <= ST_NOP;
              state <= S_PWR;
            end else begin
              cfgError <= 1'b1;
            end
          end
        end
        S_PWR: begin
          if (pwrOk) state <= S_ISSUE;
        end
        S_ISSUE: begin
          if (step == ST_FINISH) begin
            done <= 1'b1;
            state <= S_IDLE;
          end else begin
            waitCnt <= waitLoad(step);
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (waitCnt == '0) begin
            step <= step_e'(step + 4'd1);
            state <= S_ISSUE;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ddr2_init_dp.sv
module ddr2_init_dp
  import ddr2_init_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            casLat,
  input  logic [2:0]            wrRecov,
  input  logic [1:0]            dimmCount,
  input  seqStrobe_t            strb,
  output logic                  cfgOk,
  output logic                  cmdValid,
  output logic [CMD_WORD_W-1:0] cmdWord
);

  logic [2:0] casQ;
  logic [2:0] wrQ;
  logic dualQ;
  logic [2:0] wrCode;
  logic [ADDR_FIELD_W-1:0] mrAddr;
  logic [ADDR_FIELD_W-1:0] emrAddr;
  logic [CMD_WORD_W-1:0] nextWord;

  assign cfgOk = (casLat >= 3'd3) && (casLat <= 3'd5) &&
                 (wrRecov >= 3'd2) && (wrRecov <= 3'd6) &&
                 ((dimmCount == 2'd1) || (dimmCount == 2'd2));

  // Configuration is frozen for the whole run
  always_ff @(posedge clk) begin
    if (!rstN) begin
      casQ <= 3'd3;
      wrQ <= 3'd2;
      dualQ <= 1'b0;
    end else if (strb.latchCfg) begin
      casQ <= casLat;
      wrQ <= wrRecov;
      dualQ <= (dimmCount == 2'd2);
    end
  end

  assign wrCode = wrQ - 3'd1;
  // bits 11:9 write recovery, 8 DLL reset (added per step), 6:4 CAS, 2:0 burst length
  assign mrAddr = {4'd0, wrCode, 1'b0, 1'b0, casQ, 4'b0010};
  // termination and drive strength follow the DIMM load
  assign emrAddr = dualQ ? 16'h0006 : 16'h0040;

  always_comb begin
    case (strb.step)
      ST_NOP:                             nextWord = packCmd(CMD_NOP, SEL_MR, 16'h0000);
      ST_PRE_A, ST_PRE_B:                 nextWord = packCmd(CMD_PRE, SEL_MR, 16'h0400);
      ST_EMR2:                            nextWord = packCmd(CMD_MRS, SEL_EMR2, 16'h0000);
      ST_EMR3:                            nextWord = packCmd(CMD_MRS, SEL_EMR3, 16'h0000);
      ST_EMR_DLL, ST_EMR_EXIT:            nextWord = packCmd(CMD_MRS, SEL_EMR, emrAddr);
      ST_MR_RST:                          nextWord = packCmd(CMD_MRS, SEL_MR, mrAddr | 16'h0100);
      ST_REF0, ST_REF1, ST_REF2, ST_REF3: nextWord = packCmd(CMD_REF, SEL_MR, 16'h0000);
      ST_MR_RUN:                          nextWord = packCmd(CMD_MRS, SEL_MR, mrAddr);
      ST_EMR_OCD:                         nextWord = packCmd(CMD_MRS, SEL_EMR, emrAddr | 16'h0380);
      default:                            nextWord = IDLE_WORD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdWord <= IDLE_WORD;
    end else if (strb.issue) begin
      cmdValid <= 1'b1;
      cmdWord <= nextWord;
    end else begin
      cmdValid <= 1'b0;
      cmdWord <= IDLE_WORD;
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int PWRUP_CYCLES = 40000,
  parameter int T_NOP = 100,
  parameter int T_RP = 4,
  parameter int T_MRD = 2,
  parameter int T_RFC = 26,
  parameter int T_DLL = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  casLat,
  input  logic [2:0]  wrRecov,
  input  logic [1:0]  dimmCount,
  output logic        busy,
  output logic        done,
  output logic        cfgError,
  output logic        cmdValid,
  output logic [21:0] cmdWord
);

  seqStrobe_t strb;
  logic cfgOk;

  ddr2_init_ctrl #(
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .T_NOP(T_NOP),
    .T_RP(T_RP),
    .T_MRD(T_MRD),
    .T_RFC(T_RFC),
    .T_DLL(T_DLL)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .start(start),
    .cfgOk(cfgOk),
    .strb(strb),
    .busy(busy),
    .done(done),
    .cfgError(cfgError)
  );

  ddr2_init_dp i_dp (
    .clk(clk),
    .rstN(rstN),
    .casLat(casLat),
    .wrRecov(wrRecov),
    .dimmCount(dimmCount),
    .strb(strb),
    .cfgOk(cfgOk),
    .cmdValid(cmdValid),
    .cmdWord(cmdWord)
  );

endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        cfgError,
  input logic        cmdValid,
  input logic [21:0] cmdWord
);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R10
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R1
  idle_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (cmdWord == 22'h380000));

  // R2
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (!cmdWord[18] && ((cmdWord[21:19] == 3'd0) || (cmdWord[21:19] == 3'd1) ||
                                   (cmdWord[21:19] == 3'd2) || (cmdWord[21:19] == 3'd7))));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && cmdValid) |=> busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgError) |-> !busy);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

endmodule

bind ddr2_init_seq ddr2_init_chk i_chk (
  .clk(clk),
  .rstN(rstN),
  .start(start),
  .busy(busy),
  .done(done),
  .cfgError(cfgError),
  .cmdValid(cmdValid),
  .cmdWord(cmdWord)
);

// File: tb/test_ddr2_init_seq.sv
module test_ddr2_init_seq;

  localparam int CLK_NS = 20;
  localparam int PWRUP = 50;
  localparam int TNOP = 6;
  localparam int TRP = 3;
  localparam int TMRD = 2;
  localparam int TRFC = 9;
  localparam int TDLL = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] casLat = 3'd3;
  logic [2:0] wrRecov = 3'd3;
  logic [1:0] dimmCount = 2'd1;
  logic busy, done, cfgError, cmdValid;
  logic [21:0] cmdWord;

  ddr2_init_seq #(
    .PWRUP_CYCLES(PWRUP), .T_NOP(TNOP), .T_RP(TRP),
    .T_MRD(TMRD), .T_RFC(TRFC), .T_DLL(TDLL)
  ) i_ddr2_init_seq (
    .clk(clk), .rstN(rstN), .start(start), .casLat(casLat), .wrRecov(wrRecov),
    .dimmCount(dimmCount), .busy(busy), .done(done), .cfgError(cfgError),
    .cmdValid(cmdValid), .cmdWord(cmdWord)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  logic [21:0] logW [0:31];
  int logC [0:31];
  int logN = 0;

  always @(negedge clk) begin
    if (cmdValid && logN < 32) begin
      logW[logN] = cmdWord;
      logC[logN] = cyc;
      logN = logN + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] expWord(int k, int cas, int wr, int dimm);
    logic [15:0] mr, emr;
    mr = 16'h0002 | (16'(cas) << 4) | (16'(wr - 1) << 9);
    emr = (dimm == 2) ? 16'h0006 : 16'h0040;
    case (k)
      0:           return {3'd7, 1'b0, 2'd0, 16'h0000};
      1, 6:        return {3'd2, 1'b0, 2'd0, 16'h0400};
      2:           return {3'd0, 1'b0, 2'd2, 16'h0000};
      3:           return {3'd0, 1'b0, 2'd3, 16'h0000};
      4:           return {3'd0, 1'b0, 2'd1, emr};
      5:           return {3'd0, 1'b0, 2'd0, mr | 16'h0100};
      7, 8, 9, 10: return {3'd1, 1'b0, 2'd0, 16'h0000};
      11:          return {3'd0, 1'b0, 2'd0, mr};
      12:          return {3'd0, 1'b0, 2'd1, emr | 16'h0380};
      default:     return {3'd0, 1'b0, 2'd1, emr};
    endcase
  endfunction

  function automatic int expGap(int k);
    case (k)
      0:           return TNOP;
      1, 6:        return TRP;
      5:           return TDLL;
      7, 8, 9, 10: return TRFC;
      default:     return TMRD;
    endcase
  endfunction

  task automatic checkLog(int cas, int wr, int dimm, int doneCyc);
    chk(logN == 14, "R3", "command count", logN, 14);
    if (logN == 14) begin
      for (int k = 0; k < 14; k++) begin
        string req;
        req = (k == 5 || k == 11) ? "R4" : ((k == 4 || k == 12 || k == 13) ? "R5" : "R3");
        chk(logW[k] == expWord(k, cas, wr, dimm), req, $sformatf("word %0d", k),
            logW[k], expWord(k, cas, wr, dimm));
      end
      // R2 field positions: register select and command code
      chk(logW[3][17:16] == 2'd3, "R2", "EMR3 select field", logW[3][17:16], 3);
      chk(logW[7][21:19] == 3'd1, "R2", "refresh code field", logW[7][21:19], 1);
      for (int k = 0; k < 13; k++)
        chk(logC[k + 1] - logC[k] == expGap(k), "R6", $sformatf("gap after %0d", k),
            logC[k + 1] - logC[k], expGap(k));
      chk(doneCyc - logC[13] == TMRD, "R6", "done delay", doneCyc - logC[13], TMRD);
    end
  endtask

  task automatic waitDone(output int doneCyc, input bit interfere);
    doneCyc = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (interfere && i == 15) begin
        casLat = 3'd7;
        dimmCount = 2'd3;
        wrRecov = 3'd1;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        doneCyc = cyc;
        break;
      end
    end
    chk(done == 1'b1, "R9", "done reached", done, 1);
    chk(busy == 1'b0, "R9", "busy low at done", busy, 0);
  endtask

  task automatic runSeq(int cas, int wr, int dimm, bit interfere);
    int sc;
    int dc;
    @(negedge clk);
    casLat = 3'(cas);
    wrRecov = 3'(wr);
    dimmCount = 2'(dimm);
    start = 1'b1;
    logN = 0;
    sc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    chk(done == 1'b0, "R10", "done cleared by start", done, 0);
    chk(cfgError == 1'b0, "R8", "error cleared by valid start", cfgError, 0);
    waitDone(dc, interfere);
    checkLog(cas, wr, dimm, dc);
    if (logN > 0) chk(logC[0] - sc == 3, "R7", "first command delay", logC[0] - sc, 3);
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R10", "done held", done, 1);
    casLat = 3'd3;
    wrRecov = 3'd3;
    dimmCount = 2'd1;
  endtask

  task automatic errCase(int cas, int wr, int dimm);
    @(negedge clk);
    casLat = 3'(cas);
    wrRecov = 3'(wr);
    dimmCount = 2'(dimm);
    start = 1'b1;
    logN = 0;
    @(negedge clk);
    start = 1'b0;
    chk(cfgError == 1'b1, "R8", $sformatf("error flag %0d/%0d/%0d", cas, wr, dimm), cfgError, 1);
    chk(busy == 1'b0, "R8", "busy stays low", busy, 0);
    repeat (20) @(negedge clk);
    chk(logN == 0, "R8", "no commands on error", logN, 0);
    chk(cmdWord == 22'h380000, "R1", "idle word after error", cmdWord, 22'h380000);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R6 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int rel;
    int dc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(cfgError == 1'b0 && cmdValid == 1'b0, "R1", "err/valid in reset", {cfgError, cmdValid}, 0);
    chk(cmdWord == 22'h380000, "R1", "idle word in reset", cmdWord, 22'h380000);

    // Start at reset release: power-up interval governs the first command
    rstN = 1'b1;
    casLat = 3'd4;
    wrRecov = 3'd4;
    dimmCount = 2'd2;
    start = 1'b1;
    logN = 0;
    rel = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy during power-up wait", busy, 1);
    waitDone(dc, 1'b0);
    checkLog(4, 4, 2, dc);
    if (logN > 0) chk(logC[0] - rel == PWRUP + 2, "R7", "power-up gate", logC[0] - rel, PWRUP + 2);

    // Directed corners
    runSeq(3, 2, 1, 1'b0);
    runSeq(5, 6, 2, 1'b0);
    runSeq(4, 3, 2, 1'b1);
    errCase(2, 3, 1);
    runSeq(3, 5, 1, 1'b0);
    errCase(6, 3, 1);
    errCase(3, 3, 0);
    errCase(4, 4, 3);
    errCase(3, 1, 1);
    errCase(5, 7, 2);

    // Random valid configurations
    for (int n = 0; n < 8; n++) begin
      int c, w, d;
      c = 3 + int'($urandom % 3);
      w = 2 + int'($urandom % 5);
      d = 1 + int'($urandom % 2);
      runSeq(c, w, d, ($urandom % 2) == 1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule